// File: doc/BRIEF.md
# Serial Adapter Host Register Port

This block is the processor-facing side of an asynchronous serial adapter. A processor reaches it through two chip selects, a two-bit register select, a read/write line and a bus phase qualifier. Behind that decode sit a receive holding register, a transmit holding register, a status byte, a command byte and a control byte. The serial shifters sit outside the block. The receive shifter offers finished bytes and the transmit shifter takes bytes, both over valid/ready handshakes.

Reads and writes have side effects on the status flags. Taking a received byte clears the receive flags. Loading a transmit byte marks the transmitter busy. Reading status acknowledges the interrupt. Writing to the status address performs a programmed reset. The interrupt output only ever pulls low, so several adapters can share one wire.

All logic is synchronous to `clk`. A bus transfer is any `clk` rising edge at which `phi2` is high and the block is selected. Each such edge counts as one access. Receive back-pressure: `rx_ready` is always high. A byte offered while the holding register is still full is accepted on the handshake and then dropped, which raises the overrun flag. Transmit back-pressure: `tx_valid` and `tx_byte` hold steady until the shifter raises `tx_ready`.

Top module: `sio_host_regs`

## Requirements
- R1: The block is selected only when `cs_hi` is 1, `cs_lo_n` is 0 and `phi2` is 1. A write made without this selection changes no register.
- R2: `rd_data` drives a value only while the block is selected with `rd_wr_n` = 1, and is all-Z otherwise. The value comes from the register chosen by `reg_sel`: 00 = receive data, 01 = status, 10 = command, 11 = control.
- R3: A selected write with `reg_sel` 10 stores the command byte, and one with `reg_sel` 11 stores the control byte. Both appear on `cmd_q`/`ctl_q` and can be read back.
- R4: The status byte layout is: bit0 parity error, bit1 framing error, bit2 overrun, bit3 receive full, bit4 transmit empty, bit5 `line_carrier`, bit6 `line_set_ready`, bit7 interrupt pending. After reset only bit4 and the two line bits can be 1.
- R5: A byte offered while the receive register is empty is stored, sets receive full, and captures its parity and framing error bits.
- R6: A byte offered while receive full is set is dropped. The overrun bit is set and the held byte is unchanged.
- R7: Reading receive data clears receive full, parity, framing and overrun. A byte offered in that same cycle is loaded and receive full stays set.
- R8: A write with `reg_sel` 00 loads `tx_byte`, clears transmit empty and raises `tx_valid`. `tx_valid` stays high with the byte held until a cycle with `tx_ready` high, after which transmit empty is set.
- R9: Command bit0 enables the receive interrupt and bit1 enables the transmit interrupt. An offered receive byte or a completed transmit handshake, when enabled, sets interrupt pending. `irq_n` is 0 while pending and Z otherwise.
- R10: A status read clears interrupt pending. If a new enabled event arrives in the same cycle, pending stays set.
- R11: A write to `reg_sel` 01 clears the command byte and the parity, framing and overrun bits. It leaves the control byte and receive full unchanged, and the written data is ignored.
- R12: `rst_n` low clears the command, control and receive registers and the pending bit, and sets transmit empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| phi2 | input | 1 | Bus phase qualifier, high during a transfer |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| reg_sel | input | 2 | Register select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| wr_data | input | 8 | Write data from processor |
| rd_data | output | 8 | Read data, Z when not driven |
| irq_n | output | 1 | Open-drain interrupt, 0 or Z |
| rx_valid | input | 1 | Receive shifter offers a byte |
| rx_ready | output | 1 | Always 1 |
| rx_byte | input | 8 | Offered receive byte |
| rx_par_err | input | 1 | Parity error of offered byte |
| rx_frm_err | input | 1 | Framing error of offered byte |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_ready | input | 1 | Transmit shifter takes the byte |
| tx_byte | output | 8 | Byte for the transmit shifter |
| line_carrier | input | 1 | Carrier detect line level |
| line_set_ready | input | 1 | Data set ready line level |
| cmd_q | output | 8 | Command byte |
| ctl_q | output | 8 | Control byte |

## Verification
Two collisions matter most. In the first, a receive byte arrives in the same cycle that the processor reads receive data. The bench drives both in one cycle and checks three things: the read returns the older byte, receive full stays set, and a following read returns the newer byte without overrun. In the second, an enabled receive byte arrives in the same cycle as a status read. There the bench confirms that `irq_n` is still pulled low afterwards, and that a second status read releases it.

// File: rtl/sio_host_pkg.sv
package sio_host_pkg;
  localparam int BUS_W = 8;
  localparam int SEL_W = 2;
  localparam int N_REGS = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 2'b00,
    SEL_STAT = 2'b01,
    SEL_CMD  = 2'b10,
    SEL_CTL  = 2'b11
  } regsel_e;

  localparam int ST_PERR = 0;
  localparam int ST_FERR = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_RXF  = 3;
  localparam int ST_TXE  = 4;
  localparam int ST_DCD  = 5;
  localparam int ST_DSR  = 6;
  localparam int ST_IRQ  = 7;

  localparam int CMD_RXIE = 0;
  localparam int CMD_TXIE = 1;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
  import sio_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             rd_wr_n,
  output logic             bus_rd,
  output logic             rd_data_stb,
  output logic             rd_stat_stb,
  output logic [N_REGS-1:0] wr_hit
);
  logic             active;
  logic [N_REGS-1:0] hit;

  assign active = phi2 && cs_hi && !cs_lo_n;

  for (genvar g = 0; g < N_REGS; g++) begin : g_hit
    assign hit[g]    = active && (reg_sel == SEL_W'(g));
    assign wr_hit[g] = hit[g] && !rd_wr_n;
  end

  assign bus_rd      = active && rd_wr_n;
  assign rd_data_stb = hit[SEL_DATA] && rd_wr_n;
  assign rd_stat_stb = hit[SEL_STAT] && rd_wr_n;

  assert_no_write_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && cs_hi && !cs_lo_n) |-> (wr_hit == '0 && !rd_data_stb && !rd_stat_stb));
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
  import sio_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [BUS_W-1:0] rx_byte,
  input  logic             perr_in,
  input  logic             ferr_in,
  input  logic             rd_take,
  input  logic             clr_err,
  output logic             rx_ready,
  output logic             offered,
  output logic [BUS_W-1:0] data_q,
  output logic             full_q,
  output logic             perr_q,
  output logic             ferr_q,
  output logic             ovr_q
);
  logic take_new, drop;

  assign rx_ready = 1'b1;
  assign offered  = rx_valid;
  assign take_new = rx_valid && (!full_q || rd_take);
  assign drop     = rx_valid && full_q && !rd_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (clr_err) begin
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (take_new) begin
        data_q <= rx_byte;
        full_q <= 1'b1;
        perr_q <= perr_in;
        ferr_q <= ferr_in;
        ovr_q  <= 1'b0;
      end else if (rd_take) begin
        full_q <= 1'b0;
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (drop) ovr_q <= 1'b1;
    end
  end

  assert_drop_keeps_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full_q && !rd_take) |=> (ovr_q && full_q && $stable(data_q)));
  assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !rx_valid) |=> (!full_q && !ovr_q && !perr_q && !ferr_q));
  assert_race_stays_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && rx_valid) |=> full_q);
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold
  import sio_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [BUS_W-1:0] wr_byte,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [BUS_W-1:0] tx_byte,
  output logic             empty_q,
  output logic             sent
);
  assign tx_valid = !empty_q;
  assign sent     = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      empty_q <= 1'b1;
    end else if (wr_take) begin
      tx_byte <= wr_byte;
      empty_q <= 1'b0;
    end else if (sent) begin
      empty_q <= 1'b1;
    end
  end

  assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_take) |=> (tx_valid && $stable(tx_byte)));
  assert_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !empty_q);
endmodule

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic tx_evt,
  input  logic rx_ie,
  input  logic tx_ie,
  input  logic stat_rd,
  output logic pend_q
);
  logic set_evt;

  assign set_evt = (rx_evt && rx_ie) || (tx_evt && tx_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (stat_rd) pend_q <= 1'b0;
  end

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_evt && rx_ie) || (tx_evt && tx_ie)) |=> pend_q);
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(rx_evt && rx_ie) && !(tx_evt && tx_ie)) |=> !pend_q);
endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs
  import sio_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             rd_wr_n,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [BUS_W-1:0] rx_byte,
  input  logic             rx_par_err,
  input  logic             rx_frm_err,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [BUS_W-1:0] tx_byte,
  input  logic             line_carrier,
  input  logic             line_set_ready,
  output logic [BUS_W-1:0] cmd_q,
  output logic [BUS_W-1:0] ctl_q
);
  logic              bus_rd, rd_data_stb, rd_stat_stb;
  logic [N_REGS-1:0] wr_hit;
  logic              rx_offered, rx_full, perr, ferr, ovr;
  logic [BUS_W-1:0]  rx_q;
  logic              tx_empty, tx_sent, pend;
  logic [BUS_W-1:0]  status;
  logic [BUS_W-1:0]  rd_mux;

  sio_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .reg_sel(reg_sel), .rd_wr_n(rd_wr_n), .bus_rd(bus_rd),
    .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb), .wr_hit(wr_hit)
  );

  sio_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .perr_in(rx_par_err), .ferr_in(rx_frm_err), .rd_take(rd_data_stb),
    .clr_err(wr_hit[SEL_STAT]), .rx_ready(rx_ready), .offered(rx_offered),
    .data_q(rx_q), .full_q(rx_full), .perr_q(perr), .ferr_q(ferr), .ovr_q(ovr)
  );

  sio_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_hit[SEL_DATA]), .wr_byte(wr_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .empty_q(tx_empty), .sent(tx_sent)
  );

  sio_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_offered), .tx_evt(tx_sent),
    .rx_ie(cmd_q[CMD_RXIE]), .tx_ie(cmd_q[CMD_TXIE]), .stat_rd(rd_stat_stb),
    .pend_q(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_hit[SEL_STAT])     cmd_q <= '0;
      else if (wr_hit[SEL_CMD]) cmd_q <= wr_data;
      if (wr_hit[SEL_CTL])      ctl_q <= wr_data;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_PERR] = perr;
    status[ST_FERR] = ferr;
    status[ST_OVR]  = ovr;
    status[ST_RXF]  = rx_full;
    status[ST_TXE]  = tx_empty;
    status[ST_DCD]  = line_carrier;
    status[ST_DSR]  = line_set_ready;
    status[ST_IRQ]  = pend;
  end

  always_comb begin
    case (regsel_e'(reg_sel))
      SEL_DATA: rd_mux = rx_q;
      SEL_STAT: rd_mux = status;
      SEL_CMD:  rd_mux = cmd_q;
      default:  rd_mux = ctl_q;
    endcase
  end

  assign rd_data = bus_rd ? rd_mux : {BUS_W{1'bz}};
  assign irq_n   = pend ? 1'b0 : 1'bz;

  assert_prog_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[SEL_STAT] |=> (cmd_q == '0 && $stable(ctl_q)));
  assert_ctl_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[SEL_CTL] |=> $stable(ctl_q));
endmodule

// File: tb/sio_host_regs_test.sv
module sio_host_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phi2 = 1'b0, cs_hi = 1'b0, cs_lo_n = 1'b1, rd_wr_n = 1'b1;
  logic [1:0] reg_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        irq_n;
  logic       rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_ready, tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_byte, cmd_q, ctl_q;
  logic       line_carrier = 1'b1, line_set_ready = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sio_host_regs uut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .reg_sel(reg_sel), .rd_wr_n(rd_wr_n), .wr_data(wr_data), .rd_data(rd_data),
    .irq_n(irq_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .line_carrier(line_carrier),
    .line_set_ready(line_set_ready), .cmd_q(cmd_q), .ctl_q(ctl_q)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_idle();
    phi2 = 1'b0; cs_hi = 1'b0; cs_lo_n = 1'b1; rd_wr_n = 1'b1;
  endtask

  task automatic wr_raw(input logic p, input logic c0, input logic c1n,
                        input logic [1:0] rs, input logic [7:0] d);
    @(negedge clk);
    phi2 = p; cs_hi = c0; cs_lo_n = c1n; reg_sel = rs; rd_wr_n = 1'b0; wr_data = d;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic bus_wr(input logic [1:0] rs, input logic [7:0] d);
    wr_raw(1'b1, 1'b1, 1'b0, rs, d);
  endtask

  task automatic bus_rd(input logic [1:0] rs, input logic with_rx,
                        input logic [7:0] rb, output logic [7:0] v);
    @(negedge clk);
    phi2 = 1'b1; cs_hi = 1'b1; cs_lo_n = 1'b0; reg_sel = rs; rd_wr_n = 1'b1;
    rx_valid = with_rx; rx_byte = rb; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    #2 v = rd_data;
    @(negedge clk);
    bus_idle();
    rx_valid = 1'b0;
  endtask

  task automatic offer(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_par_err = pe; rx_frm_err = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 idle bus floats", rd_data, 8'hzz);
    chk("R9 irq released after reset", {7'b0, irq_n}, {7'b0, 1'bz});
    chk("R12 cmd reset", cmd_q, 8'h00);
    chk("R12 ctl reset", ctl_q, 8'h00);
    chk("R8 tx_valid low after reset", {7'b0, tx_valid}, 8'h00);
    chk("R5 rx_ready high", {7'b0, rx_ready}, 8'h01);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R4 reset status", v, 8'h30);
  endtask

  task automatic t_select();
    logic [7:0] v;
    wr_raw(1'b1, 1'b0, 1'b0, 2'b11, 8'hEE);
    chk("R1 cs_hi low ignores write", ctl_q, 8'h00);
    wr_raw(1'b1, 1'b1, 1'b1, 2'b11, 8'hEE);
    chk("R1 cs_lo_n high ignores write", ctl_q, 8'h00);
    wr_raw(1'b0, 1'b1, 1'b0, 2'b11, 8'hEE);
    chk("R1 phi2 low ignores write", ctl_q, 8'h00);
    @(negedge clk);
    phi2 = 1'b1; cs_hi = 1'b0; cs_lo_n = 1'b0; reg_sel = 2'b01; rd_wr_n = 1'b1;
    #2 v = rd_data;
    chk("R2 unselected read floats", v, 8'hzz);
    @(negedge clk);
    bus_idle();
  endtask

  task automatic t_cmdctl();
    logic [7:0] v;
    bus_wr(2'b10, 8'h58);
    bus_wr(2'b11, 8'hA5);
    chk("R3 cmd stored", cmd_q, 8'h58);
    chk("R3 ctl stored", ctl_q, 8'hA5);
    bus_rd(2'b10, 1'b0, 8'h00, v);
    chk("R3 cmd readback", v, 8'h58);
    bus_rd(2'b11, 1'b0, 8'h00, v);
    chk("R3 ctl readback", v, 8'hA5);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    offer(8'h3C, 1'b1, 1'b0);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R5 status after byte", v, 8'h39);
    bus_rd(2'b00, 1'b0, 8'h00, v);
    chk("R5 received data", v, 8'h3C);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R7 status cleared by data read", v, 8'h30);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    offer(8'h11, 1'b0, 1'b0);
    offer(8'h22, 1'b0, 1'b1);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R6 overrun status", v, 8'h3C);
    bus_rd(2'b00, 1'b0, 8'h00, v);
    chk("R6 older byte kept", v, 8'h11);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R7 overrun cleared", v, 8'h30);
  endtask

  task automatic t_rx_race();
    logic [7:0] v;
    offer(8'h44, 1'b0, 1'b0);
    bus_rd(2'b00, 1'b1, 8'h55, v);
    chk("R7 race read returns older", v, 8'h44);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R7 race keeps full no overrun", v, 8'h38);
    bus_rd(2'b00, 1'b0, 8'h00, v);
    chk("R7 race newer byte", v, 8'h55);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    bus_wr(2'b00, 8'h81);
    chk("R8 tx_valid raised", {7'b0, tx_valid}, 8'h01);
    chk("R8 tx_byte", tx_byte, 8'h81);
    repeat (2) @(negedge clk);
    chk("R8 tx held without ready", {tx_valid, tx_byte[6:0]}, 8'h81);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R8 status tx busy", v, 8'h20);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R8 tx_valid drops", {7'b0, tx_valid}, 8'h00);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R8 status tx empty", v, 8'h30);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_wr(2'b10, 8'h01);
    offer(8'h66, 1'b0, 1'b0);
    chk("R9 rx irq asserted", {7'b0, irq_n}, 8'h00);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R9 pending bit in status", v, 8'hB8);
    chk("R10 status read releases irq", {7'b0, irq_n}, {7'b0, 1'bz});
    bus_rd(2'b00, 1'b0, 8'h00, v);
    offer(8'h67, 1'b0, 1'b0);
    bus_rd(2'b01, 1'b1, 8'h68, v);
    chk("R10 event in ack cycle keeps irq", {7'b0, irq_n}, 8'h00);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R10 second ack releases", {7'b0, irq_n}, {7'b0, 1'bz});
    bus_rd(2'b00, 1'b0, 8'h00, v);
    bus_wr(2'b10, 8'h02);
    bus_wr(2'b00, 8'h09);
    chk("R9 no tx irq before handshake", {7'b0, irq_n}, {7'b0, 1'bz});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R9 tx irq asserted", {7'b0, irq_n}, 8'h00);
    bus_rd(2'b01, 1'b0, 8'h00, v);
  endtask

  task automatic t_prog_reset();
    logic [7:0] v;
    bus_wr(2'b11, 8'h77);
    bus_wr(2'b10, 8'h00);
    offer(8'h12, 1'b1, 1'b1);
    offer(8'h13, 1'b0, 1'b0);
    bus_wr(2'b10, 8'hC8);
    bus_wr(2'b01, 8'hFF);
    chk("R11 cmd cleared", cmd_q, 8'h00);
    chk("R11 ctl kept", ctl_q, 8'h77);
    bus_rd(2'b01, 1'b0, 8'h00, v);
    chk("R11 errors cleared full kept", v, 8'h38);
    bus_rd(2'b00, 1'b0, 8'h00, v);
    chk("R11 held byte kept", v, 8'h12);
  endtask

  task automatic t_hw_reset();
    bus_wr(2'b10, 8'h5A);
    bus_wr(2'b00, 8'h42);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12 cmd cleared by reset", cmd_q, 8'h00);
    chk("R12 ctl cleared by reset", ctl_q, 8'h00);
    chk("R12 tx empty after reset", {7'b0, tx_valid}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_cmdctl();
    t_rx();
    t_overrun();
    t_rx_race();
    t_tx();
    t_irq();
    t_prog_reset();
    t_hw_reset();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule